// File: doc/BRIEF.md
# Inter-Processor FIFO Mailbox

This unit lets two processors, called side A and side B, exchange 32-bit words and a small status nibble over one shared clock. Each side reaches the unit through its own register port, which has a valid strobe, a write enable, a 2-bit register select and a 32-bit data bus. The read data is registered and appears in the cycle after the access. Behind each port sit three registers: a 16-bit handshake register, a 16-bit queue control/status register and a 32-bit data window.

Each side owns a 16-deep, 32-bit queue. Writing the data window pushes a word into the writer's own queue. Reading the data window takes a word from the other side's queue. The handshake register carries a 4-bit value from each side into the low nibble of the other side's handshake register. Both control registers always show consistent empty and full flags for both queues. A sticky error flag records a read from an empty queue and a push into a full queue. When a read finds the queue empty, a per-side latch supplies the word that side last received.

When both sides access the unit in the same cycle, side A's access takes effect before side B's access.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both control registers read 0x0101 (the own queue and the peer queue are both empty), both handshake registers read 0, and a data read that finds nothing returns 0.
- R2: A write to the handshake register (select 0) takes bits 8-11, 13 and 14 from the written value. Every other bit of that register ignores the write.
- R3: Bits 8-11 of one side's handshake register appear in bits 0-3 of the other side's handshake register from the cycle after the write.
- R4: A write to the control register (select 1) stores bits 2, 3, 10 and 15 from the written value. Bits 0, 1, 8 and 9 are read-only status. The other bits read 0.
- R5: Control bit 14 is the error flag. Writing 1 to it clears it, and writing 0 to it leaves it unchanged.
- R6: A write to the data window (select 2) pushes the word into the writer's own queue only when the writer's control bit 15 is 1. Otherwise the write is ignored.
- R7: In each control register, bit 0 is own-queue-empty, bit 1 is own-queue-full, bit 8 is peer-queue-empty and bit 9 is peer-queue-full. A queue counts as full at exactly 16 words. The flags follow every push and pop in the next cycle.
- R8: A data read (select 2) returns the head word of the peer's queue. The read removes that word only when the reader's bit 15 is 1. When bit 15 is 0, the read leaves the queue unchanged.
- R9: A data read that finds the peer queue empty sets the reader's error flag and returns the last word that side read successfully.
- R10: A push into a full queue is dropped, and it sets the pusher's error flag. The queue contents stay unchanged.
- R11: In a same-cycle conflict, side A goes first. A word that A pushes into its empty queue is delivered to a simultaneous B read. A simultaneous B push does not reach an A read made in the same cycle.
- R12: Select 3 reads 0, and writes to select 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_sel | input | 2 | Side A register select: 0 handshake, 1 control, 2 data, 3 none |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after the access |
| b_valid | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_sel | input | 2 | Side B register select |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after the access |

## Verification
Every result of an access sampled at clock edge N is due one register stage later. The read data, the new queue counts and the status flags, the error flag and the cross-side nibble are all visible after edge N. A control read issued at edge N+1 returns those new values.

The bench drives each access on a falling edge. It holds the access for one rising edge, then samples the read data on the following falling edge. After every push and pop it issues a separate control read, so each flag check sees the state produced by exactly one prior access.

// File: rtl/ipc_mbox_pkg.sv
// Package: shared constants and the register-select encoding for the
// two-sided mailbox. Assumes 16-bit control registers and 32-bit data words.
package ipc_mbox_pkg;

    localparam int DATA_W = 32;
    localparam int REG_W  = 16;

    typedef enum logic [1:0] {
        SEL_SYNC = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Writable handshake bits: outgoing nibble 8-11 plus bits 13 and 14.
    localparam logic [REG_W-1:0] SYNC_WMASK = 16'h6F00;
    // Control bits stored straight from a write (error flag handled apart).
    localparam logic [REG_W-1:0] CTRL_STORE = 16'h840C;
    localparam int ERR_BIT = 14;
    localparam int EN_BIT  = 15;

endpackage

// File: rtl/ipc_queue.sv
// Module: one word queue with a parameter-chosen order for a push and a pop
// that arrive in the same cycle. PUSH_FIRST=1 lets a push into an empty queue
// be read in that cycle. PUSH_FIRST=0 serves the pop from the old contents
// and lets a push into a full queue take the slot the pop frees.
// Assumes DEPTH >= 2 and at most one push and one pop per cycle.
module ipc_queue #(
    parameter int DEPTH      = 16,
    parameter int DW         = 32,
    parameter bit PUSH_FIRST = 1'b1,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          push_ok,
    output logic          avail,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt_q;
    logic          full, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;

    generate
        if (PUSH_FIRST) begin : g_push_first
            // Push is applied before the pop: a word pushed into an empty queue is readable now.
            assign push_ok = push && !full;
            assign avail   = push_ok || (cnt_q != '0);
            assign head    = (cnt_q == '0) ? push_data : mem[rptr];
        end else begin : g_pop_first
            // Pop is applied before the push: it sees only old contents and frees a slot.
            assign avail   = (cnt_q != '0);
            assign head    = mem[rptr];
            assign push_ok = push && (!full || pop);
        end
    endgenerate

    assign pop_ok = pop && avail;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/ipc_port.sv
// Module: register view of one side. It decodes accesses, holds the handshake
// bits, the stored control bits, the sticky error flag, the last-read latch
// and the registered read data. Assumes one access per cycle on this port.
// The queues and the peer's nibble arrive from outside.
module ipc_port
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        peer_nib,
    input  logic [CW-1:0]     tx_count,
    input  logic [CW-1:0]     rx_count,
    input  logic              push_ok,
    input  logic              rx_avail,
    input  logic [DATA_W-1:0] rx_word,
    output logic [3:0]        own_nib,
    output logic              push_req,
    output logic              rx_pop,
    output logic [DATA_W-1:0] rdata
);

    logic [REG_W-1:0]  sync_q, ctrl_q;
    logic              err_q;
    logic [DATA_W-1:0] last_q, rdata_q;
    logic              wr_sync, wr_ctrl, rx_req, en;
    logic [REG_W-1:0]  sync_view, ctrl_view;

    assign en       = ctrl_q[EN_BIT];
    assign wr_sync  = valid && wr && (sel == SEL_SYNC);
    assign wr_ctrl  = valid && wr && (sel == SEL_CTRL);
    assign push_req = valid && wr && (sel == SEL_DATA) && en;
    assign rx_req   = valid && !wr && (sel == SEL_DATA);
    assign rx_pop   = rx_req && en;
    assign own_nib  = sync_q[11:8];

    // Assemble readable views from stored bits and live queue status.
    always_comb begin
        sync_view = sync_q | {12'h000, peer_nib};
        ctrl_view = ctrl_q;
        ctrl_view[ERR_BIT] = err_q;
        ctrl_view[0] = (tx_count == '0);
        ctrl_view[1] = (tx_count == CW'(DEPTH));
        ctrl_view[8] = (rx_count == '0);
        ctrl_view[9] = (rx_count == CW'(DEPTH));
    end

    // Capture writable handshake and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_sync) sync_q <= wdata[REG_W-1:0] & SYNC_WMASK;
            if (wr_ctrl) ctrl_q <= wdata[REG_W-1:0] & CTRL_STORE;
        end
    end

    // Sticky error flag: set by an empty read or a dropped push, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_ctrl && wdata[ERR_BIT]) begin
            err_q <= 1'b0;
        end else if ((push_req && !push_ok) || (rx_req && !rx_avail)) begin
            err_q <= 1'b1;
        end
    end

    // Remember the last word delivered to this side.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else if (rx_req && rx_avail) last_q <= rx_word;
    end

    // Register the read data of a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (valid && !wr) begin
            case (sel)
                SEL_SYNC: rdata_q <= {16'h0000, sync_view};
                SEL_CTRL: rdata_q <= {16'h0000, ctrl_view};
                SEL_DATA: rdata_q <= rx_avail ? rx_word : last_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

    p_err_on_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_avail) |=> err_q);

    p_err_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[ERR_BIT]) |=> !err_q);

    p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[ERR_BIT] && err_q) |=> err_q);

    p_no_push_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wr && (sel == SEL_DATA) && !en) |-> !push_req);

endmodule

// File: rtl/ipc_mailbox.sv
// Module: top of the two-sided mailbox. A generate loop builds one register
// port and one queue per side. Side s pushes into queue s and reads queue 1-s.
// Queue 0 (A pushes, B pops) applies its push first, and queue 1 (B pushes,
// A pops) applies its pop first, so A always goes before B within a cycle.
// Assumes a single clock and synchronous active-low reset.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic              a_wr,
    input  logic [1:0]        a_sel,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_valid,
    input  logic              b_wr,
    input  logic [1:0]        b_sel,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic              valid_s [2];
    logic              wr_s    [2];
    logic [1:0]        sel_s   [2];
    logic [DATA_W-1:0] wdata_s [2];
    logic [DATA_W-1:0] rdata_s [2];
    logic [3:0]        nib_s   [2];
    logic              push_s  [2];
    logic              pok_s   [2];
    logic              pop_s   [2];
    logic              avail_q [2];
    logic [DATA_W-1:0] head_q  [2];
    logic [CW-1:0]     cnt_q   [2];

    // Map the named side ports onto per-side arrays.
    always_comb begin
        valid_s[0] = a_valid;  wr_s[0] = a_wr;  sel_s[0] = a_sel;  wdata_s[0] = a_wdata;
        valid_s[1] = b_valid;  wr_s[1] = b_wr;  sel_s[1] = b_sel;  wdata_s[1] = b_wdata;
    end

    assign a_rdata = rdata_s[0];
    assign b_rdata = rdata_s[1];

    generate
        for (genvar s = 0; s < 2; s++) begin : g_side
            localparam int O = 1 - s;

            ipc_queue #(
                .DEPTH      (DEPTH),
                .DW         (DATA_W),
                .PUSH_FIRST (s == 0)
            ) u_queue (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_s[s]),
                .push_data (wdata_s[s]),
                .pop       (pop_s[O]),
                .push_ok   (pok_s[s]),
                .avail     (avail_q[s]),
                .head      (head_q[s]),
                .count     (cnt_q[s])
            );

            ipc_port #(
                .DEPTH (DEPTH)
            ) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid    (valid_s[s]),
                .wr       (wr_s[s]),
                .sel      (sel_s[s]),
                .wdata    (wdata_s[s]),
                .peer_nib (nib_s[O]),
                .tx_count (cnt_q[s]),
                .rx_count (cnt_q[O]),
                .push_ok  (pok_s[s]),
                .rx_avail (avail_q[O]),
                .rx_word  (head_q[O]),
                .own_nib  (nib_s[s]),
                .push_req (push_s[s]),
                .rx_pop   (pop_s[s]),
                .rdata    (rdata_s[s])
            );
        end
    endgenerate

    p_sync_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_wr && (a_sel == 2'd0)) |=> (nib_s[0] == $past(a_wdata[11:8])));

    p_order_a_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_s[0] && (cnt_q[0] == '0) && pop_s[1]) |=> (cnt_q[0] == '0));

endmodule

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 0, a_wr = 0, b_valid = 0, b_wr = 0;
    logic [1:0]  a_sel = 0, b_sel = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ipc_mailbox u_ipc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_wr(a_wr), .a_sel(a_sel), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_valid(b_valid), .b_wr(b_wr), .b_sel(b_sel), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access on one side (s=0 A, s=1 B); read data sampled a cycle later.
    task automatic acc(input int s, input logic w, input logic [1:0] sel,
                       input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        if (s == 0) begin a_valid = 1; a_wr = w; a_sel = sel; a_wdata = d; end
        else        begin b_valid = 1; b_wr = w; b_sel = sel; b_wdata = d; end
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        r = (s == 0) ? a_rdata : b_rdata;
    endtask

    // Simultaneous access on both sides.
    task automatic both(input logic aw, input logic [1:0] asel, input logic [31:0] ad,
                        input logic bw, input logic [1:0] bsel, input logic [31:0] bd,
                        output logic [31:0] ar, output logic [31:0] br);
        @(negedge clk);
        a_valid = 1; a_wr = aw; a_sel = asel; a_wdata = ad;
        b_valid = 1; b_wr = bw; b_sel = bsel; b_wdata = bd;
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        ar = a_rdata; br = b_rdata;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    function automatic logic [31:0] word(input int i);
        return 32'hA500_0000 | (i * 32'h0001_0101);
    endfunction

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        acc(0, 0, 2'd1, 0, r); chk("R1 A ctrl", r, 32'h0101);
        acc(1, 0, 2'd1, 0, r); chk("R1 B ctrl", r, 32'h0101);
        acc(0, 0, 2'd0, 0, r); chk("R1 A sync", r, 32'h0);
        acc(1, 0, 2'd0, 0, r); chk("R1 B sync", r, 32'h0);

        // R12 unused select
        acc(0, 1, 2'd3, 32'hFFFF_FFFF, r);
        acc(0, 0, 2'd3, 0, r); chk("R12 sel3 read", r, 32'h0);
        acc(0, 0, 2'd1, 0, r); chk("R12 ctrl untouched", r, 32'h0101);
        acc(0, 0, 2'd0, 0, r); chk("R12 sync untouched", r, 32'h0);

        // R9 empty read before any word: returns 0, sets error
        acc(1, 0, 2'd2, 0, r); chk("R1 R9 empty read value", r, 32'h0);
        acc(1, 0, 2'd1, 0, r); chk("R9 B err set", r, 32'h4101);
        // R5 write 0 keeps, write 1 clears
        acc(1, 1, 2'd1, 32'h0, r);
        acc(1, 0, 2'd1, 0, r); chk("R5 write0 keeps err", r, 32'h4101);
        acc(1, 1, 2'd1, 32'h4000, r);
        acc(1, 0, 2'd1, 0, r); chk("R5 write1 clears err", r, 32'h0101);

        // R2 R3 handshake masking and crossing
        acc(0, 1, 2'd0, 32'hFFFF, r);
        acc(0, 0, 2'd0, 0, r); chk("R2 A sync mask", r, 32'h6F00);
        acc(1, 0, 2'd0, 0, r); chk("R3 B sees nibble", r, 32'h000F);
        acc(1, 1, 2'd0, 32'h90FF, r);
        acc(1, 0, 2'd0, 0, r); chk("R2 B sync mask", r, 32'h000F);
        acc(0, 0, 2'd0, 0, r); chk("R3 A sees B nibble 0", r, 32'h6F00);
        for (int n = 0; n < 16; n++) begin
            acc(0, 1, 2'd0, 32'hF0F5 | (n << 8), r);
            acc(0, 0, 2'd0, 0, r); chk("R2 A sync sweep", r, 32'h6000 | (n << 8));
            acc(1, 0, 2'd0, 0, r); chk("R3 B nibble sweep", r, n);
        end

        // R4 control masking, status read-only
        acc(0, 1, 2'd1, 32'hFFFF, r);
        acc(0, 0, 2'd1, 0, r); chk("R4 A ctrl all ones", r, 32'h850D);
        acc(0, 1, 2'd1, 32'h0000, r);
        acc(0, 0, 2'd1, 0, r); chk("R4 A ctrl zero", r, 32'h0101);
        acc(0, 1, 2'd1, 32'h8000, r);
        acc(0, 0, 2'd1, 0, r); chk("R4 A enabled", r, 32'h8101);

        // R6 disabled push by B ignored
        acc(1, 1, 2'd2, 32'hDEAD_BEEF, r);
        acc(0, 0, 2'd1, 0, r); chk("R6 A sees peer empty", r, 32'h8101);
        acc(1, 0, 2'd1, 0, r); chk("R6 B own empty", r, 32'h0101);

        // R7 fill A queue, flags on both sides
        for (int k = 1; k <= 16; k++) begin
            acc(0, 1, 2'd2, word(k - 1), r);
            acc(0, 0, 2'd1, 0, r); chk("R7 A flags fill", r, 32'h8100 | ((k == 16) ? 2 : 0));
            acc(1, 0, 2'd1, 0, r); chk("R7 B flags fill", r, 32'h0001 | ((k == 16) ? 32'h200 : 0));
        end

        // R10 push into full queue dropped, error set
        acc(0, 1, 2'd2, 32'h0BAD_0BAD, r);
        acc(0, 0, 2'd1, 0, r); chk("R10 A err on full", r, 32'hC102);

        // R8 peek while disabled
        acc(1, 0, 2'd2, 0, r); chk("R8 peek 1", r, word(0));
        acc(1, 0, 2'd2, 0, r); chk("R8 peek 2", r, word(0));
        acc(1, 0, 2'd1, 0, r); chk("R8 peek keeps full", r, 32'h0201);
        acc(1, 1, 2'd1, 32'h8000, r);

        // R8 drain with pop; R10 dropped word never appears
        for (int i = 0; i < 16; i++) begin
            acc(1, 0, 2'd2, 0, r); chk("R8 R10 pop order", r, word(i));
            acc(1, 0, 2'd1, 0, r); chk("R7 B flags drain", r, 32'h8001 | ((i == 15) ? 32'h100 : 0));
            acc(0, 0, 2'd1, 0, r); chk("R7 A flags drain", r, 32'hC100 | ((i == 15) ? 1 : 0));
        end

        // R9 empty read replays last word
        acc(1, 0, 2'd2, 0, r); chk("R9 replay last", r, word(15));
        acc(1, 0, 2'd1, 0, r); chk("R9 B err", r, 32'hC101);
        acc(0, 1, 2'd1, 32'hC000, r);
        acc(1, 1, 2'd1, 32'hC000, r);
        acc(0, 0, 2'd1, 0, r); chk("R5 A cleared", r, 32'h8101);
        acc(1, 0, 2'd1, 0, r); chk("R5 B cleared", r, 32'h8101);

        // R11 A push and B pop same cycle: B gets the word
        both(1, 2'd2, 32'h1111_2222, 0, 2'd2, 0, r, r2);
        chk("R11 B gets A push", r2, 32'h1111_2222);
        acc(0, 0, 2'd1, 0, r); chk("R11 A queue empty", r, 32'h8101);
        acc(1, 0, 2'd1, 0, r); chk("R11 B no err", r, 32'h8101);
        // R11 B push and A pop same cycle: A pop goes first and finds nothing
        both(0, 2'd2, 0, 1, 2'd2, 32'h3333_4444, r, r2);
        chk("R11 A empty first", r, 32'h0);
        acc(0, 0, 2'd1, 0, r); chk("R11 A err and peer word", r, 32'hC001);
        acc(0, 0, 2'd2, 0, r); chk("R11 A gets word later", r, 32'h3333_4444);
        acc(0, 0, 2'd1, 0, r); chk("R7 A peer empty again", r, 32'hC101);

        finish_run();
    end

endmodule